// File: doc/BRIEF.md
# Rotating-Priority Interrupt Request Resolver

This block keeps the request and in-service state of one eight-input interrupt controller and decides which request, if any, goes to the processor. Each input line is set to edge or level sensing on its own. Captured requests sit in a pending register and are gated by a mask. The strongest unmasked request is found under a programmable rotating base. It is offered only when it outranks the strongest bit already in service.

The programming logic around the block supplies the mask, the sense selection and the mode bits as registered levels. It also drives the acknowledge, end-of-service and base-write strobes. The processor side sees a valid flag and a 3-bit index. The pending and in-service vectors are also brought out so that the programming block can read them back.

Top module: `irq_resolver`

## Requirements
- R1: After reset (rst_ni low), pending_o, in_service_o and the rotation base are all zero, and irq_valid_o is 0.
- R2: On an input with level_sel_i bit = 1 (level sensing), the pending bit on the next clock equals the line value sampled on that clock.
- R3: On an input with level_sel_i bit = 0 (edge sensing), the pending bit sets only on a clock where the line is high and was low on the previous clock. A low line never clears it, and a line held high after an acknowledge does not set it again.
- R4: The winner is the pending, unmasked bit at the smallest offset k, scanning bits (k + base) mod 8 from k = 0. irq_idx_o gives the bit number, (k + base) mod 8.
- R5: A bit set in mask_i is never presented. Its pending bit is kept, and pending_o still shows it.
- R6: irq_valid_o is 1 only when the winner's offset is strictly smaller than the offset of the strongest in-service bit. An empty in-service vector counts as offset 8.
- R7: When nested_mode_i is 1 on a master instance (IS_MASTER = 1), in-service bit 2 is left out of the in-service offset computation.
- R8: ack_i while irq_valid_o is 1 sets the in-service bit at irq_idx_o and clears that pending bit only if the input is edge-sensed. A level-sensed pending bit stays set.
- R9: With auto_eoi_i = 1, an acknowledge leaves in_service_o unchanged. If auto_rotate_i is also 1, the base becomes (irq_idx_o + 1) mod 8.
- R10: eoi_i clears the in-service bit selected by eoi_idx_i on the next clock.
- R11: base_we_i loads base_i into the rotation base. Later picks use the new base.
- R12: ack_i while irq_valid_o is 0 leaves pending_o and in_service_o unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 8 | Interrupt request lines |
| level_sel_i | input | 8 | Per-line sensing: 1 = level, 0 = edge |
| mask_i | input | 8 | Per-line mask, 1 = blocked |
| nested_mode_i | input | 1 | Leave in-service bit 2 out of the ranking (master only) |
| auto_eoi_i | input | 1 | Acknowledge does not hold an in-service bit |
| auto_rotate_i | input | 1 | With auto_eoi_i, acknowledge rotates the base past the served line |
| base_we_i | input | 1 | Load base_i into the rotation base |
| base_i | input | 3 | New rotation base |
| ack_i | input | 1 | Processor acknowledge of the presented request |
| eoi_i | input | 1 | Clear one in-service bit |
| eoi_idx_i | input | 3 | In-service bit cleared by eoi_i |
| irq_valid_o | output | 1 | A request is presented |
| irq_idx_o | output | 3 | Line number of the presented request |
| pending_o | output | 8 | Pending register |
| in_service_o | output | 8 | In-service register |

## Verification
The bench holds an edge-sensed line high across an acknowledge. A design that re-arms on level instead of on a rising edge would present the same line again at once. It rotates the base so that a numerically higher line wins. A resolver that ignored the base, or added it on the wrong side, would report line 1. It offers a lower-ranked request and a request of equal rank while a bit is in service, which catches a compare that is not strict. It also checks that nested mode is the one thing that lets line 2 re-enter. Finally it acknowledges a level-sensed line and an empty request. A design that cleared level pending bits, or acted on an acknowledge with nothing valid, would show the change on pending_o or in_service_o.

// File: rtl/irq_pkg.sv
package irq_pkg;
  localparam int unsigned IRQ_N = 8;
  localparam int unsigned IRQ_W = $clog2(IRQ_N);
  localparam int unsigned CASCADE_BIT = 2;

  typedef logic [IRQ_N-1:0] irq_vec_t;
  typedef logic [IRQ_W-1:0] irq_idx_t;
endpackage

// File: rtl/irq_req_latch.sv
module irq_req_latch #(
  parameter int unsigned N = irq_pkg::IRQ_N
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] req_i,
  input  logic [N-1:0] level_sel_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] pend_o
);
  logic [N-1:0] pend_q, prev_q, pend_d;

  for (genvar i = 0; i < N; i++) begin : g_bit
    always_comb begin
      if (level_sel_i[i]) pend_d[i] = req_i[i];
      else                pend_d[i] = (pend_q[i] | (req_i[i] & ~prev_q[i])) & ~clr_i[i];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q <= '0;
      prev_q <= '0;
    end else begin
      pend_q <= pend_d;
      prev_q <= req_i;
    end
  end

  assign pend_o = pend_q;

  p_level_follow_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((pend_q & $past(level_sel_i)) == ($past(req_i) & $past(level_sel_i))));

  p_edge_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (($past(pend_q) & ~$past(level_sel_i) & ~$past(clr_i) & ~pend_q) == '0));
endmodule

// File: rtl/irq_prio_pick.sv
module irq_prio_pick #(
  parameter int unsigned N          = irq_pkg::IRQ_N,
  parameter int unsigned W          = irq_pkg::IRQ_W,
  parameter bit          IS_MASTER  = 1'b1,
  parameter int unsigned CASC_BIT   = irq_pkg::CASCADE_BIT
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] pend_i,
  input  logic [N-1:0] mask_i,
  input  logic [N-1:0] isr_i,
  input  logic [W-1:0] base_i,
  input  logic         nested_mode_i,
  output logic         valid_o,
  output logic [W-1:0] idx_o
);
  // Offset of the first set bit, scanning from base; N means empty.
  function automatic logic [W:0] scan(input logic [N-1:0] v, input logic [W-1:0] b);
    logic [W:0]   r;
    logic [W-1:0] pos;
    r = (W+1)'(N);
    for (int k = N - 1; k >= 0; k--) begin
      pos = W'(k) + b;
      if (v[pos]) r = (W+1)'(k);
    end
    return r;
  endfunction

  logic [N-1:0] live_req, isr_rank;
  logic [W:0]   req_off, isr_off;

  if (IS_MASTER) begin : g_master
    always_comb begin
      isr_rank = isr_i;
      if (nested_mode_i) isr_rank[CASC_BIT] = 1'b0;
    end
  end else begin : g_slave
    assign isr_rank = isr_i;
  end

  assign live_req = pend_i & ~mask_i;
  assign req_off  = scan(live_req, base_i);
  assign isr_off  = scan(isr_rank, base_i);
  assign valid_o  = req_off < isr_off;
  assign idx_o    = req_off[W-1:0] + base_i;

  p_idx_unmasked_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> (pend_i[idx_o] && !mask_i[idx_o]));

  p_not_in_service_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> !isr_rank[idx_o]);
endmodule

// File: rtl/irq_isr_ctrl.sv
module irq_isr_ctrl #(
  parameter int unsigned N = irq_pkg::IRQ_N,
  parameter int unsigned W = irq_pkg::IRQ_W
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         ack_i,
  input  logic         valid_i,
  input  logic [W-1:0] idx_i,
  input  logic [N-1:0] level_sel_i,
  input  logic         auto_eoi_i,
  input  logic         auto_rotate_i,
  input  logic         base_we_i,
  input  logic [W-1:0] base_i,
  input  logic         eoi_i,
  input  logic [W-1:0] eoi_idx_i,
  output logic [N-1:0] isr_o,
  output logic [W-1:0] base_o,
  output logic [N-1:0] pend_clr_o
);
  logic [N-1:0] isr_q, isr_d;
  logic [W-1:0] base_q, base_d;
  logic         ack_fire;

  assign ack_fire = ack_i & valid_i;

  always_comb begin
    isr_d  = isr_q;
    base_d = base_q;
    if (ack_fire && !auto_eoi_i) isr_d[idx_i] = 1'b1;
    if (ack_fire && auto_eoi_i && auto_rotate_i) base_d = idx_i + W'(1);
    if (eoi_i) isr_d[eoi_idx_i] = 1'b0;
    if (base_we_i) base_d = base_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      isr_q  <= '0;
      base_q <= '0;
    end else begin
      isr_q  <= isr_d;
      base_q <= base_d;
    end
  end

  assign pend_clr_o = ack_fire ? ((N'(1) << idx_i) & ~level_sel_i) : '0;
  assign isr_o      = isr_q;
  assign base_o     = base_q;

  p_ack_sets_isr_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_fire && !auto_eoi_i && !eoi_i) |=> isr_q[$past(idx_i)]);

  p_auto_eoi_keep_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_fire && auto_eoi_i && !eoi_i) |=> (isr_q == $past(isr_q)));

  p_eoi_clears_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    eoi_i |=> !isr_q[$past(eoi_idx_i)]);

  p_idle_ack_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_i && !valid_i && !eoi_i) |=> $stable(isr_q));
endmodule

// File: rtl/irq_resolver.sv
module irq_resolver #(
  parameter int unsigned N         = irq_pkg::IRQ_N,
  parameter int unsigned W         = irq_pkg::IRQ_W,
  parameter bit          IS_MASTER = 1'b1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] req_i,
  input  logic [N-1:0] level_sel_i,
  input  logic [N-1:0] mask_i,
  input  logic         nested_mode_i,
  input  logic         auto_eoi_i,
  input  logic         auto_rotate_i,
  input  logic         base_we_i,
  input  logic [W-1:0] base_i,
  input  logic         ack_i,
  input  logic         eoi_i,
  input  logic [W-1:0] eoi_idx_i,
  output logic         irq_valid_o,
  output logic [W-1:0] irq_idx_o,
  output logic [N-1:0] pending_o,
  output logic [N-1:0] in_service_o
);
  logic [N-1:0] pend, isr, pend_clr;
  logic [W-1:0] base;
  logic         valid;
  logic [W-1:0] idx;

  irq_req_latch #(.N(N)) u_latch (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .req_i       (req_i),
    .level_sel_i (level_sel_i),
    .clr_i       (pend_clr),
    .pend_o      (pend)
  );

  irq_prio_pick #(.N(N), .W(W), .IS_MASTER(IS_MASTER)) u_pick (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .pend_i        (pend),
    .mask_i        (mask_i),
    .isr_i         (isr),
    .base_i        (base),
    .nested_mode_i (nested_mode_i),
    .valid_o       (valid),
    .idx_o         (idx)
  );

  irq_isr_ctrl #(.N(N), .W(W)) u_isr (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .ack_i         (ack_i),
    .valid_i       (valid),
    .idx_i         (idx),
    .level_sel_i   (level_sel_i),
    .auto_eoi_i    (auto_eoi_i),
    .auto_rotate_i (auto_rotate_i),
    .base_we_i     (base_we_i),
    .base_i        (base_i),
    .eoi_i         (eoi_i),
    .eoi_idx_i     (eoi_idx_i),
    .isr_o         (isr),
    .base_o        (base),
    .pend_clr_o    (pend_clr)
  );

  assign irq_valid_o  = valid;
  assign irq_idx_o    = idx;
  assign pending_o    = pend;
  assign in_service_o = isr;

  p_reset_quiet_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rst_ni) |-> (pending_o == '0 && in_service_o == '0));
endmodule

// File: tb/irq_resolver_test.sv
module irq_resolver_test;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic [7:0] req_i = '0, level_sel_i = '0, mask_i = '0;
  logic       nested_mode_i = 1'b0, auto_eoi_i = 1'b0, auto_rotate_i = 1'b0;
  logic       base_we_i = 1'b0, ack_i = 1'b0, eoi_i = 1'b0;
  logic [2:0] base_i = '0, eoi_idx_i = '0;
  logic       irq_valid_o;
  logic [2:0] irq_idx_o;
  logic [7:0] pending_o, in_service_o;

  int errors = 0;
  int checks = 0;

  always #4 clk_i = ~clk_i;

  irq_resolver uut (.*);

  task automatic tick();
    @(posedge clk_i);
    #1;
  endtask

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_ni = 1'b0;
    req_i = '0; level_sel_i = '0; mask_i = '0;
    nested_mode_i = 0; auto_eoi_i = 0; auto_rotate_i = 0;
    base_we_i = 0; ack_i = 0; eoi_i = 0; base_i = '0; eoi_idx_i = '0;
    tick();
    rst_ni = 1'b1;
    tick();
  endtask

  task automatic do_ack();
    ack_i = 1; tick(); ack_i = 0;
  endtask

  task automatic do_eoi(input logic [2:0] i);
    eoi_idx_i = i; eoi_i = 1; tick(); eoi_i = 0;
  endtask

  task automatic set_base(input logic [2:0] b);
    base_i = b; base_we_i = 1; tick(); base_we_i = 0;
  endtask

  task automatic t_reset();
    req_i = 8'h81; tick(); ack_i = 1;
    rst_ni = 0; #1;
    chk("R1 valid", irq_valid_o, 0);
    chk("R1 pending", pending_o, 0);
    chk("R1 isr", in_service_o, 0);
    do_reset();
    req_i = 8'h81; tick();
    chk("R1 base zero idx", irq_idx_o, 0);
  endtask

  task automatic t_level();
    do_reset();
    level_sel_i = 8'h08; req_i = 8'h08; tick();
    chk("R2 level set", pending_o, 8'h08);
    chk("R2 level idx", irq_idx_o, 3);
    req_i = 8'h00; tick();
    chk("R2 level clear", pending_o, 0);
    chk("R2 level no valid", irq_valid_o, 0);
    req_i = 8'h08; tick(); do_ack();
    chk("R8 level ack isr", in_service_o, 8'h08);
    chk("R8 level pend kept", pending_o, 8'h08);
  endtask

  task automatic t_edge();
    do_reset();
    req_i = 8'h20; tick();
    chk("R3 edge set", pending_o, 8'h20);
    req_i = 8'h00; tick();
    chk("R3 low keeps", pending_o, 8'h20);
    chk("R3 idx", irq_idx_o, 5);
    do_ack();
    chk("R8 edge ack isr", in_service_o, 8'h20);
    chk("R8 edge pend clr", pending_o, 0);
    do_eoi(5);
    chk("R10 eoi", in_service_o, 0);
    req_i = 8'h20; tick(); do_ack(); do_eoi(5); tick();
    chk("R3 held high no retrigger", pending_o, 0);
    chk("R3 held high no valid", irq_valid_o, 0);
  endtask

  task automatic t_rotate_mask();
    do_reset();
    req_i = 8'h82; tick();
    chk("R4 base0", irq_idx_o, 1);
    set_base(4);
    chk("R11 base4", irq_idx_o, 7);
    set_base(2);
    chk("R11 base2", irq_idx_o, 7);
    set_base(0);
    chk("R11 base0 again", irq_idx_o, 1);
    mask_i = 8'h02; tick();
    chk("R5 mask one", irq_idx_o, 7);
    mask_i = 8'h82; tick();
    chk("R5 all masked valid", irq_valid_o, 0);
    chk("R5 pending kept", pending_o, 8'h82);
    do_ack();
    chk("R12 idle ack pend", pending_o, 8'h82);
    chk("R12 idle ack isr", in_service_o, 0);
  endtask

  task automatic t_nesting();
    do_reset();
    req_i = 8'h10; tick(); do_ack();
    req_i = 8'h50; tick();
    chk("R6 lower blocked", irq_valid_o, 0);
    req_i = 8'h54; tick();
    chk("R6 higher wins", irq_idx_o, 2);
    chk("R6 higher valid", irq_valid_o, 1);
    do_ack();
    chk("R6 isr two bits", in_service_o, 8'h14);
    do_eoi(2);
    chk("R6 still blocked", irq_valid_o, 0);
    do_eoi(4);
    chk("R6 released", irq_idx_o, 6);
    chk("R6 released valid", irq_valid_o, 1);
  endtask

  task automatic t_fully_nested();
    do_reset();
    req_i = 8'h04; tick(); do_ack();
    req_i = 8'h24; tick();
    chk("R7 off blocked", irq_valid_o, 0);
    nested_mode_i = 1; tick();
    chk("R7 on idx", irq_idx_o, 5);
    req_i = 8'h20; tick(); req_i = 8'h24; tick();
    chk("R7 bit2 reenters", irq_idx_o, 2);
    chk("R7 bit2 valid", irq_valid_o, 1);
    nested_mode_i = 0; tick();
    chk("R7 off again", irq_valid_o, 0);
  endtask

  task automatic t_auto_eoi();
    do_reset();
    auto_eoi_i = 1;
    req_i = 8'h08; tick(); do_ack();
    chk("R9 no isr", in_service_o, 0);
    chk("R9 pend cleared", pending_o, 0);
    auto_rotate_i = 1;
    req_i = 8'h4A; tick();
    chk("R9 pick before rotate", irq_idx_o, 1);
    do_ack();
    chk("R9 pend after", pending_o, 8'h40);
    req_i = 8'h48; tick(); req_i = 8'h4A; tick();
    chk("R9 rotated pick", irq_idx_o, 6);
  endtask

  initial begin
    do_reset();
    t_reset();
    t_level();
    t_edge();
    t_rotate_mask();
    t_nesting();
    t_fully_nested();
    t_auto_eoi();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(8 * 100000);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule